// File: doc/BRIEF.md
# Load/Store Address Generator

This block forms the memory address and the base-register update value for a load or store. One offset is chosen from three sources: a 12-bit immediate, an index register value, or that index register scaled through a shifter. The offset is then added to or subtracted from a 32-bit base. An indexing mode decides which value goes to memory and which goes back to the base register.

In offset mode, the access uses base±offset and the base is not updated. In pre-indexed mode, base±offset is used for the access and is also written back. In post-indexed mode, the access uses the plain base and base±offset is written back. All results are registered, so each set of inputs produces its result one clock later. The register file, the memory access itself and alignment checking belong to other blocks.

Top module: `mem_addr_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `acc_addr`, `wb_value` and `wb_en` as zero.
- R2: With `off_src` = 2'b00, the offset is `imm_off` zero-extended to 32 bits. An immediate of 0xFFF therefore adds 4095 and never a negative value.
- R3: With `off_src` = 2'b01, the offset is `idx_val` unchanged.
- R4: With `off_src` = 2'b10, the offset is `idx_val` shifted by `shamt` (0..31). The `shift_kind` codes are: 2'b00 logical left, 2'b01 logical right, 2'b10 arithmetic right, and 2'b11 acts as logical left.
- R5: `add_sel` = 1 adds the offset to the base and `add_sel` = 0 subtracts it. The result wraps modulo 2^32 and no overflow indication is produced.
- R6: `idx_mode` = 2'b00 (offset) gives `acc_addr` = base±offset, `wb_value` = base and `wb_en` = 0.
- R7: `idx_mode` = 2'b01 (pre-indexed) gives `acc_addr` = `wb_value` = base±offset and `wb_en` = 1.
- R8: `idx_mode` = 2'b10 (post-indexed) gives `acc_addr` = base, `wb_value` = base±offset and `wb_en` = 1.
- R9: The reserved codes act as defaults: `idx_mode` = 2'b11 behaves as offset mode, and `off_src` = 2'b11 behaves as the immediate source.
- R10: Outputs change only at a rising edge. Each one reflects the inputs sampled at the most recent edge, which gives a latency of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_val | input | 32 | Base register value |
| imm_off | input | 12 | Immediate offset (unsigned) |
| idx_val | input | 32 | Index register value |
| off_src | input | 2 | Offset source select |
| shift_kind | input | 2 | Scaling shift type |
| shamt | input | 5 | Scaling shift amount |
| add_sel | input | 1 | 1 = add offset, 0 = subtract |
| idx_mode | input | 2 | Indexing mode |
| acc_addr | output | 32 | Memory access address |
| wb_value | output | 32 | Base writeback value |
| wb_en | output | 1 | Base writeback enable |

## Verification
The block keeps no state apart from its output register, so any internal fault shows up at the ports in the cycle right after the faulty inputs are sampled. A wrong source or shift selection appears as a wrong offset in `acc_addr` or `wb_value`, depending on the mode. A mode decode error shows up as swapped address and writeback values or a wrong `wb_en`. A broken output register or reset shows as a value that lands a cycle early or late, or as a non-zero output right after reset.

// File: rtl/mag_pkg.sv
package mag_pkg;
  typedef enum logic [1:0] {
    SRC_IMM = 2'b00,
    SRC_IDX = 2'b01,
    SRC_SCL = 2'b10,
    SRC_RSV = 2'b11
  } off_src_e;

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ALT = 2'b11
  } shift_e;

  typedef enum logic [1:0] {
    MODE_OFFSET = 2'b00,
    MODE_PRE    = 2'b01,
    MODE_POST   = 2'b10,
    MODE_RSV    = 2'b11
  } idx_mode_e;
endpackage

// File: rtl/mag_offset.sv
module mag_offset #(
  parameter int DW = 32,
  parameter int IW = 12,
  parameter int SW = 5
) (
  input  logic [IW-1:0] imm,
  input  logic [DW-1:0] idx,
  input  logic [1:0]    src,
  input  logic [1:0]    kind,
  input  logic [SW-1:0] amt,
  output logic [DW-1:0] off
);
  import mag_pkg::*;
  localparam int PAD = DW - IW;

  logic [DW-1:0] imm_ext;
  logic [DW-1:0] scaled;

  assign imm_ext = {{PAD{1'b0}}, imm};

  // R4: barrel shift of the index register
  always_comb begin
    case (shift_e'(kind))
      SH_LSR:  scaled = idx >> amt;
      SH_ASR:  scaled = DW'($signed(idx) >>> amt);
      default: scaled = idx << amt;
    endcase
  end

  always_comb begin
    case (off_src_e'(src))
      SRC_IDX: off = idx;
      SRC_SCL: off = scaled;
      default: off = imm_ext;
    endcase
  end
endmodule

// File: rtl/mag_addsub.sv
module mag_addsub #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] base,
  input  logic [DW-1:0] off,
  input  logic          up,
  output logic [DW-1:0] sum
);
  // R5: modulo-2^DW arithmetic, carry discarded
  assign sum = up ? (base + off) : (base - off);
endmodule

// File: rtl/mag_mode_sel.sv
module mag_mode_sel #(
  parameter int DW = 32
) (
  input  logic [1:0]    mode,
  input  logic [DW-1:0] base,
  input  logic [DW-1:0] sum,
  output logic [DW-1:0] addr,
  output logic [DW-1:0] wb,
  output logic          en
);
  import mag_pkg::*;
  always_comb begin
    case (idx_mode_e'(mode))
      MODE_PRE: begin
        addr = sum;
        wb   = sum;
        en   = 1'b1;
      end
      MODE_POST: begin
        addr = base;
        wb   = sum;
        en   = 1'b1;
      end
      default: begin
        addr = sum;
        wb   = base;
        en   = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/mem_addr_gen.sv
module mem_addr_gen #(
  parameter int DW = 32,
  parameter int IW = 12,
  parameter int SW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] base_val,
  input  logic [IW-1:0] imm_off,
  input  logic [DW-1:0] idx_val,
  input  logic [1:0]    off_src,
  input  logic [1:0]    shift_kind,
  input  logic [SW-1:0] shamt,
  input  logic          add_sel,
  input  logic [1:0]    idx_mode,
  output logic [DW-1:0] acc_addr,
  output logic [DW-1:0] wb_value,
  output logic          wb_en
);
  logic [DW-1:0] off_w, sum_w, addr_n, wb_n;
  logic          en_n;

  mag_offset #(.DW(DW), .IW(IW), .SW(SW)) u_off (
    .imm (imm_off),
    .idx (idx_val),
    .src (off_src),
    .kind(shift_kind),
    .amt (shamt),
    .off (off_w)
  );

  mag_addsub #(.DW(DW)) u_sum (
    .base(base_val),
    .off (off_w),
    .up  (add_sel),
    .sum (sum_w)
  );

  mag_mode_sel #(.DW(DW)) u_mode (
    .mode(idx_mode),
    .base(base_val),
    .sum (sum_w),
    .addr(addr_n),
    .wb  (wb_n),
    .en  (en_n)
  );

  // R1, R10: single output register stage
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_addr <= '0;
      wb_value <= '0;
      wb_en    <= 1'b0;
    end else begin
      acc_addr <= addr_n;
      wb_value <= wb_n;
      wb_en    <= en_n;
    end
  end
endmodule

// File: rtl/mag_checker.sv
module mag_checker #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] base_val,
  input logic [1:0]    idx_mode,
  input logic [DW-1:0] acc_addr,
  input logic [DW-1:0] wb_value,
  input logic          wb_en
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (acc_addr == '0 && wb_value == '0 && !wb_en));

  assert_offset_keeps_base_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(idx_mode) == 2'b00) |-> (!wb_en && wb_value == $past(base_val)));

  assert_pre_same_value_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(idx_mode) == 2'b01) |-> (wb_en && acc_addr == wb_value));

  assert_post_plain_base_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(idx_mode) == 2'b10) |-> (wb_en && acc_addr == $past(base_val)));

  assert_rsv_mode_no_wb_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(idx_mode) == 2'b11) |-> (!wb_en && wb_value == $past(base_val)));
endmodule

bind mem_addr_gen mag_checker #(.DW(DW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .base_val(base_val),
  .idx_mode(idx_mode),
  .acc_addr(acc_addr),
  .wb_value(wb_value),
  .wb_en   (wb_en)
);

// File: tb/mem_addr_gen_test.sv
module mem_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] base_val = '0;
  logic [11:0] imm_off = '0;
  logic [31:0] idx_val = '0;
  logic [1:0]  off_src = '0;
  logic [1:0]  shift_kind = '0;
  logic [4:0]  shamt = '0;
  logic        add_sel = 1'b1;
  logic [1:0]  idx_mode = '0;
  logic [31:0] acc_addr, wb_value;
  logic        wb_en;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  mem_addr_gen uut (
    .clk(clk), .rst(rst), .base_val(base_val), .imm_off(imm_off),
    .idx_val(idx_val), .off_src(off_src), .shift_kind(shift_kind),
    .shamt(shamt), .add_sel(add_sel), .idx_mode(idx_mode),
    .acc_addr(acc_addr), .wb_value(wb_value), .wb_en(wb_en)
  );

  typedef struct packed {
    logic [31:0] base;
    logic [11:0] imm;
    logic [31:0] idx;
    logic [1:0]  src;
    logic [1:0]  kind;
    logic [4:0]  amt;
    logic        up;
    logic [1:0]  mode;
    logic [31:0] e_addr;
    logic [31:0] e_wb;
    logic        e_en;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_1000, 12'h004, 32'h0,          2'b00, 2'b00, 5'd0,  1'b1, 2'b00, 32'h0000_1004, 32'h0000_1000, 1'b0}, // R2 R6
    '{32'h0000_1000, 12'hFFF, 32'h0,          2'b00, 2'b00, 5'd0,  1'b1, 2'b01, 32'h0000_1FFF, 32'h0000_1FFF, 1'b1}, // R2 R7
    '{32'h0000_1000, 12'h000, 32'h10,         2'b01, 2'b00, 5'd0,  1'b0, 2'b10, 32'h0000_1000, 32'h0000_0FF0, 1'b1}, // R3 R8
    '{32'h0000_1000, 12'h000, 32'h3,          2'b10, 2'b00, 5'd2,  1'b1, 2'b00, 32'h0000_100C, 32'h0000_1000, 1'b0}, // R4 lsl
    '{32'h0,         12'h000, 32'h8000_0000,  2'b10, 2'b01, 5'd4,  1'b1, 2'b00, 32'h0800_0000, 32'h0,         1'b0}, // R4 lsr
    '{32'h0,         12'h000, 32'h8000_0000,  2'b10, 2'b10, 5'd4,  1'b1, 2'b00, 32'hF800_0000, 32'h0,         1'b0}, // R4 asr
    '{32'h0,         12'h000, 32'h5,          2'b10, 2'b11, 5'd1,  1'b1, 2'b00, 32'h0000_000A, 32'h0,         1'b0}, // R4 code 11
    '{32'h0,         12'h000, 32'h8000_0000,  2'b10, 2'b10, 5'd31, 1'b1, 2'b00, 32'hFFFF_FFFF, 32'h0,         1'b0}, // R4 asr 31
    '{32'h0,         12'h000, 32'h1234,       2'b10, 2'b01, 5'd0,  1'b1, 2'b00, 32'h0000_1234, 32'h0,         1'b0}, // R4 amt 0
    '{32'hFFFF_FFF0, 12'h020, 32'h0,          2'b00, 2'b00, 5'd0,  1'b1, 2'b01, 32'h0000_0010, 32'h0000_0010, 1'b1}, // R5 wrap up
    '{32'h0000_0008, 12'h000, 32'h10,         2'b01, 2'b00, 5'd0,  1'b0, 2'b00, 32'hFFFF_FFF8, 32'h0000_0008, 1'b0}, // R5 wrap down
    '{32'h0000_2000, 12'h008, 32'h0,          2'b00, 2'b00, 5'd0,  1'b1, 2'b11, 32'h0000_2008, 32'h0000_2000, 1'b0}, // R9 mode 11
    '{32'h0000_0100, 12'h010, 32'h999,        2'b11, 2'b00, 5'd0,  1'b1, 2'b00, 32'h0000_0110, 32'h0000_0100, 1'b0}  // R9 src 11
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    base_val = v.base; imm_off = v.imm; idx_val = v.idx; off_src = v.src;
    shift_kind = v.kind; shamt = v.amt; add_sel = v.up; idx_mode = v.mode;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs zero under reset
    check("R1 addr", acc_addr, 32'h0);
    check("R1 wb", wb_value, 32'h0);
    check("R1 en", {31'b0, wb_en}, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      @(posedge clk); #1;
      check($sformatf("R10 vec%0d addr", i), acc_addr, VECS[i].e_addr);
      check($sformatf("R10 vec%0d wb", i), wb_value, VECS[i].e_wb);
      check($sformatf("R10 vec%0d en", i), {31'b0, wb_en}, {31'b0, VECS[i].e_en});
    end

    // R10: a new input does not reach the outputs before the next edge
    apply(VECS[0]);
    @(posedge clk); #1;
    apply(VECS[2]);
    #5;
    check("R10 hold addr", acc_addr, 32'h0000_1004);
    check("R10 hold en", {31'b0, wb_en}, 32'h0);
    @(posedge clk); #1;
    check("R8 post addr", acc_addr, 32'h0000_1000);
    check("R8 post wb", wb_value, 32'h0000_0FF0);

    // R1: reset asserted mid-stream clears a pre-indexed result
    apply(VECS[1]);
    @(posedge clk); #1;
    check("R7 pre en", {31'b0, wb_en}, 32'h1);
    rst = 1'b1;
    @(posedge clk); #1;
    check("R1 mid addr", acc_addr, 32'h0);
    check("R1 mid en", {31'b0, wb_en}, 32'h0);
    rst = 1'b0;
    @(posedge clk); #1;
    check("R7 after reset", acc_addr, 32'h0000_1FFF);

    finish_run();
  end
endmodule